// File: doc/BRIEF.md
# Radix-2² Feedback FFT Stage Pair

This block is one stage pair of a streaming, decimation-in-frequency FFT pipeline built on the radix-2² split. It takes one complex sample per accepted cycle. Two add/subtract butterflies each use their own feedback delay line, one N/2 samples deep and one N/4 samples deep, where N is the span the pair covers. Between the two butterflies sits a rotation by −j. That rotation is only a swap of the real and imaginary parts with one sign change. A complex multiplier then applies twiddle factors from a small table, which is computed when the design elaborates. The result is the work of a radix-4 DIF step, done with radix-2 arithmetic and one multiplier.

Several of these pairs are chained to build a longer transform. A processor whose length is chosen at run time sets `bypass` on the leading pairs it does not need. A bypassed pair forwards its input with one cycle of latency and lowers `gate_en`, so that a clock gate outside the block can stop the pair's internal state. Each butterfly halves its result with rounding, so a pair scales its output by 1/4 overall. Results leave the pair in bit-reversed quarter order.

Top module: `r22_sdf_stage`

## Requirements
- R1: After reset, with `bypass` low, `out_valid` is 0 and `gate_en` is 1.
- R2: The first valid output of each frame starts a group of N outputs that has four quarters of N/4 values each. The quarters carry the frequency index k = 0, 2, 1, 3, in that order, and the index n rises from 0 inside each quarter. Each value equals (1/4)·Σ_{l=0..3} x[n+l·N/4]·(−j)^{l·k}·e^{−j2π·n·k/N}, within ±3 LSB on each part.
- R3: Counting from reset, or from the end of a bypass, `out_valid` goes high for the first time on the cycle after the (3N/4+3)-th accepted sample. That output is position 0 of the frame that began with the first accepted sample.
- R4: A cycle with `in_valid` low is not counted as a sample and has no effect on the results. In the cycle after such a cycle, `out_valid` is 0 and the outputs keep their values.
- R5: `out_valid` is high only in the cycle after a cycle in which `in_valid` was high.
- R6: While `bypass` is high, `out_re`/`out_im`/`out_valid` equal `in_re`/`in_im`/`in_valid` of the previous cycle.
- R7: `gate_en` is the inverse of `bypass`.
- R8: Leaving bypass restarts frame alignment. The first sample accepted afterwards is sample 0 of a new frame, whatever was fed before the bypass.
- R9: An impulse of amplitude A (a multiple of 4) at sample 0 of a frame, with zeros elsewhere, gives exactly A/4 + j0 at the n = 0 position of all four quarters, and exactly 0 at every other position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bypass | input | 1 | Skip this pair: forward input, clear frame alignment |
| in_valid | input | 1 | Input sample present |
| in_re | input | DW | Input real part, signed |
| in_im | input | DW | Input imaginary part, signed |
| out_valid | output | 1 | Output sample present |
| out_re | output | DW | Output real part, signed |
| out_im | output | DW | Output imaginary part, signed |
| gate_en | output | 1 | Clock enable for an external gate on this pair |

## Verification
The hardest case to reach is the −j rotation interacting with the second delay line under stalls. The rotated samples only feed the k = 1 and k = 3 quarters, and a zero or constant input makes those quarters vanish. A complex tone at a bin that is not a multiple of four is therefore streamed over two frames, with idle cycles inserted at a regular interval. The bench checks every output against its own radix-4 DIF sum. An interrupted partial frame followed by a bypass pulse then shows that stale delay-line contents never leak into valid outputs.

// File: rtl/r22_pkg.sv
package r22_pkg;

  // clamp a value to the signed range of w bits
  function automatic longint sat_w(input longint v, input int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // (a + b) / 2, rounded half up
  function automatic longint half_sum(input longint a, input longint b);
    return (a + b + 1) >>> 1;
  endfunction

  // (a - b) / 2, rounded half up
  function automatic longint half_diff(input longint a, input longint b);
    return (a - b + 1) >>> 1;
  endfunction

  // arithmetic right shift by s with rounding half up
  function automatic longint rnd_shr(input longint v, input int s);
    return (v + (longint'(1) <<< (s - 1))) >>> s;
  endfunction

endpackage

// File: rtl/r22_sdf_bf.sv
module r22_sdf_bf
  import r22_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 step,
  input  logic                 bfly,
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  output logic signed [DW-1:0] y_re,
  output logic signed [DW-1:0] y_im
);
  // feedback storage; contents before the first fill are never observed
  logic signed [DW-1:0] dl_re [DEPTH];
  logic signed [DW-1:0] dl_im [DEPTH];
  logic signed [DW-1:0] head_re, head_im;
  logic signed [DW-1:0] push_re, push_im;

  assign head_re = dl_re[DEPTH-1];
  assign head_im = dl_im[DEPTH-1];

  always_comb begin
    if (bfly) begin
      y_re    = DW'(half_sum(longint'(head_re), longint'(a_re)));
      y_im    = DW'(half_sum(longint'(head_im), longint'(a_im)));
      push_re = DW'(half_diff(longint'(head_re), longint'(a_re)));
      push_im = DW'(half_diff(longint'(head_im), longint'(a_im)));
    end else begin
      y_re    = head_re;
      y_im    = head_im;
      push_re = a_re;
      push_im = a_im;
    end
  end

  always_ff @(posedge clk) begin
    if (step) begin
      dl_re[0] <= push_re;
      dl_im[0] <= push_im;
      for (int i = 1; i < DEPTH; i++) begin
        dl_re[i] <= dl_re[i-1];
        dl_im[i] <= dl_im[i-1];
      end
    end
  end
endmodule

// File: rtl/r22_twiddle.sv
module r22_twiddle #(
  parameter int LOG_N = 4,
  parameter int TW_W  = 16
) (
  input  logic [LOG_N-1:0]       idx,
  output logic signed [TW_W-1:0] w_re,
  output logic signed [TW_W-1:0] w_im
);
  localparam int  N  = 1 << LOG_N;
  localparam real SC = 2.0 ** (TW_W - 2);

  logic signed [TW_W-1:0] tab_re [N];
  logic signed [TW_W-1:0] tab_im [N];

  // entry i holds e^{-j*2*pi*i/N}, with 1.0 at 2^(TW_W-2)
  for (genvar i = 0; i < N; i++) begin : g_tab
    localparam real ANG = 6.283185307179586 * i / N;
    localparam real CV  = $cos(ANG) * SC;
    localparam real SV  = -$sin(ANG) * SC;
    localparam int  CI  = (CV >= 0.0) ? $rtoi(CV + 0.5) : -$rtoi(0.5 - CV);
    localparam int  SI  = (SV >= 0.0) ? $rtoi(SV + 0.5) : -$rtoi(0.5 - SV);
    assign tab_re[i] = CI[TW_W-1:0];
    assign tab_im[i] = SI[TW_W-1:0];
  end

  assign w_re = tab_re[idx];
  assign w_im = tab_im[idx];
endmodule

// File: rtl/r22_cmul.sv
module r22_cmul
  import r22_pkg::*;
#(
  parameter int DW   = 16,
  parameter int TW_W = 16
) (
  input  logic signed [DW-1:0]   a_re,
  input  logic signed [DW-1:0]   a_im,
  input  logic signed [TW_W-1:0] w_re,
  input  logic signed [TW_W-1:0] w_im,
  output logic signed [DW-1:0]   p_re,
  output logic signed [DW-1:0]   p_im
);
  longint full_re, full_im;

  always_comb begin
    full_re = longint'(a_re) * longint'(w_re) - longint'(a_im) * longint'(w_im);
    full_im = longint'(a_re) * longint'(w_im) + longint'(a_im) * longint'(w_re);
    p_re    = DW'(sat_w(rnd_shr(full_re, TW_W - 2), DW));
    p_im    = DW'(sat_w(rnd_shr(full_im, TW_W - 2), DW));
  end
endmodule

// File: rtl/r22_sdf_stage.sv
module r22_sdf_stage
  import r22_pkg::*;
#(
  parameter int DW    = 16,
  parameter int LOG_N = 4,   // span of this pair is 2^LOG_N, at least 8
  parameter int TW_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bypass,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im,
  output logic                 gate_en
);
  localparam int N     = 1 << LOG_N;
  localparam int D1    = N / 2;
  localparam int D2    = N / 4;
  localparam int START = 3 * N / 4;

  // named internal events
  logic step;        // a sample is accepted by the pipeline
  logic bf1_bfly;    // first butterfly combines instead of filling
  logic bf2_bfly;    // second butterfly combines instead of filling
  logic rot_on;      // -j applied to the sample entering butterfly two
  logic first_good;  // frame position 0 is entering butterfly two

  logic [LOG_N-1:0] cnt, r1c, r2c;
  logic signed [DW-1:0] r1_re, r1_im, r2_re, r2_im;
  logic r2g, warm;

  logic signed [DW-1:0] b1_re, b1_im, rt_re, rt_im, b2_re, b2_im;
  logic signed [DW-1:0] m_re, m_im;
  logic signed [TW_W-1:0] w_re, w_im;
  logic [1:0] tq, tk;
  logic [LOG_N-1:0] tw_idx;

  assign step       = in_valid & ~bypass;
  assign gate_en    = ~bypass;
  assign bf1_bfly   = cnt[LOG_N-1];
  assign bf2_bfly   = r1c[LOG_N-2];
  assign rot_on     = (r1c[LOG_N-1:LOG_N-2] == 2'b01);
  assign first_good = (r1c == LOG_N'(START));

  r22_sdf_bf #(.DW(DW), .DEPTH(D1)) u_bf1 (
    .clk(clk), .step(step), .bfly(bf1_bfly),
    .a_re(in_re), .a_im(in_im), .y_re(b1_re), .y_im(b1_im)
  );

  // -j * (re + j im) = im - j re
  always_comb begin
    if (rot_on) begin
      rt_re = r1_im;
      rt_im = DW'(sat_w(-longint'(r1_re), DW));
    end else begin
      rt_re = r1_re;
      rt_im = r1_im;
    end
  end

  r22_sdf_bf #(.DW(DW), .DEPTH(D2)) u_bf2 (
    .clk(clk), .step(step), .bfly(bf2_bfly),
    .a_re(rt_re), .a_im(rt_im), .y_re(b2_re), .y_im(b2_im)
  );

  // quarter within the output frame, then its bit-reversed frequency index
  assign tq     = r2c[LOG_N-1:LOG_N-2] + 2'd1;
  assign tk     = {tq[0], tq[1]};
  assign tw_idx = LOG_N'(r2c[LOG_N-3:0]) * LOG_N'(tk);

  r22_twiddle #(.LOG_N(LOG_N), .TW_W(TW_W)) u_rom (
    .idx(tw_idx), .w_re(w_re), .w_im(w_im)
  );

  r22_cmul #(.DW(DW), .TW_W(TW_W)) u_mul (
    .a_re(r2_re), .a_im(r2_im), .w_re(w_re), .w_im(w_im),
    .p_re(m_re), .p_im(m_im)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      r1c       <= '0;
      r2c       <= '0;
      r1_re     <= '0;
      r1_im     <= '0;
      r2_re     <= '0;
      r2_im     <= '0;
      r2g       <= 1'b0;
      warm      <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
      out_valid <= 1'b0;
    end else if (bypass) begin
      out_re    <= in_re;
      out_im    <= in_im;
      out_valid <= in_valid;
      cnt       <= '0;
      r1c       <= '0;
      r2g       <= 1'b0;
      warm      <= 1'b0;
    end else begin
      out_valid <= step & r2g;
      if (step) begin
        cnt    <= cnt + 1'b1;
        r1_re  <= b1_re;
        r1_im  <= b1_im;
        r1c    <= cnt;
        r2_re  <= b2_re;
        r2_im  <= b2_im;
        r2c    <= r1c;
        r2g    <= warm | first_good;
        warm   <= warm | first_good;
        out_re <= m_re;
        out_im <= m_im;
      end
    end
  end
endmodule

// File: rtl/r22_sdf_stage_chk.sv
module r22_sdf_stage_chk #(
  parameter int DW    = 16,
  parameter int LOG_N = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bypass,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_re,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_re,
  input logic                 step,
  input logic                 rot_on,
  input logic                 bf2_bfly
);
  localparam int FIRST = 3 * (1 << LOG_N) / 4 + 3;

  int seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    seen <= 0;
    else if (bypass)               seen <= 0;
    else if (step && seen < FIRST) seen <= seen + 1;
  end

  // R6
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (out_valid == $past(in_valid)) && (out_re == $past(in_re)));

  // R4
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !bypass) |=> $stable(out_re));

  // R3
  warmup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(bypass)) |-> (seen >= FIRST));

  // R2
  rot_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rot_on |-> bf2_bfly);
endmodule

bind r22_sdf_stage r22_sdf_stage_chk #(.DW(DW), .LOG_N(LOG_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .bypass(bypass), .in_valid(in_valid),
  .in_re(in_re), .out_valid(out_valid), .out_re(out_re),
  .step(step), .rot_on(rot_on), .bf2_bfly(bf2_bfly)
);

// File: tb/r22_sdf_stage_test.sv
module r22_sdf_stage_test;
  localparam int DW = 16;
  localparam int LOG_N = 4;
  localparam int N = 1 << LOG_N;
  localparam int Q = N / 4;
  localparam int FIRST = 3 * N / 4 + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bypass = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_re = '0, in_im = '0;
  logic out_valid, gate_en;
  logic signed [DW-1:0] out_re, out_im;

  always #5 clk = ~clk;

  r22_sdf_stage #(.DW(DW), .LOG_N(LOG_N), .TW_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .in_valid(in_valid),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid),
    .out_re(out_re), .out_im(out_im), .gate_en(gate_en)
  );

  int total = 0, bad = 0;
  int fed = 0, got_n = 0, first_fed = -1, r5_viol = 0;
  int got_re [256], got_im [256];
  int st_re [64], st_im [64];
  logic iv_q = 1'b0;

  always @(posedge clk) iv_q <= in_valid;

  always @(negedge clk) begin
    if (out_valid) begin
      if (!iv_q) r5_viol++;
      if (got_n == 0) first_fed = fed;
      if (got_n < 256) begin
        got_re[got_n] = out_re;
        got_im[got_n] = out_im;
      end
      got_n++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input int re, input int im);
    @(negedge clk);
    in_valid = v;
    in_re = DW'(re);
    in_im = DW'(im);
    @(posedge clk);
    if (v) fed++;
  endtask

  task automatic restart();
    @(negedge clk);
    in_valid = 1'b0;
    bypass = 1'b1;
    repeat (2) @(negedge clk);
    bypass = 1'b0;
    got_n = 0;
    fed = 0;
    first_fed = -1;
  endtask

  // stream nsamp samples of st_*, zero beyond index 63, idle every 5th slot if gaps
  task automatic stream(input int nsamp, input bit gaps);
    for (int t = 0; t < nsamp; t++) begin
      if (gaps && (t % 5 == 2)) drive(1'b0, 0, 0);
      if (t < 64) drive(1'b1, st_re[t], st_im[t]);
      else        drive(1'b1, 0, 0);
    end
    drive(1'b0, 0, 0);
    drive(1'b0, 0, 0);
  endtask

  function automatic int brev2(input int q);
    return ((q & 1) << 1) | ((q >> 1) & 1);
  endfunction

  task automatic check_impulse(input string tag);
    check(first_fed == FIRST, "R3", first_fed, FIRST);
    for (int p = 0; p < N; p++) begin
      int er;
      er = (p % Q == 0) ? 1000 : 0;
      check(got_re[p] == er, tag, got_re[p], er);
      check(got_im[p] == 0, tag, got_im[p], 0);
    end
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    check(gate_en == 1'b1, "R1/R7", int'(gate_en), 1);
  endtask

  task automatic t_impulse();
    for (int t = 0; t < 64; t++) begin st_re[t] = 0; st_im[t] = 0; end
    st_re[0] = 4000;
    restart();
    stream(3 * N, 1'b0);
    check_impulse("R9");
  endtask

  task automatic t_tone();
    for (int t = 0; t < 64; t++) begin
      real a;
      a = 6.283185307179586 * 3.0 * t / N;
      st_re[t] = (t < 2 * N) ? int'(3000.0 * $cos(a)) : 0;
      st_im[t] = (t < 2 * N) ? int'(3000.0 * $sin(a)) : 0;
    end
    restart();
    stream(3 * N, 1'b1);
    check(got_n >= 2 * N, "R4", got_n, 2 * N);
    for (int f = 0; f < 2; f++) begin
      for (int p = 0; p < N; p++) begin
        int k, n, idx, er, ei;
        real sr, si, th;
        k = brev2(p / Q);
        n = p % Q;
        sr = 0.0;
        si = 0.0;
        for (int l = 0; l < 4; l++) begin
          th = -1.5707963267948966 * l * k - 6.283185307179586 * n * k / N;
          sr += st_re[f*N + n + l*Q] * $cos(th) - st_im[f*N + n + l*Q] * $sin(th);
          si += st_re[f*N + n + l*Q] * $sin(th) + st_im[f*N + n + l*Q] * $cos(th);
        end
        er = int'(sr / 4.0);
        ei = int'(si / 4.0);
        idx = f * N + p;
        check(got_re[idx] - er <= 3 && er - got_re[idx] <= 3, "R2 re", got_re[idx], er);
        check(got_im[idx] - ei <= 3 && ei - got_im[idx] <= 3, "R2 im", got_im[idx], ei);
      end
    end
    check(r5_viol == 0, "R5", r5_viol, 0);
  endtask

  task automatic t_bypass();
    @(negedge clk);
    bypass = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    check(gate_en == 1'b0, "R7", int'(gate_en), 0);
    for (int i = 0; i < 10; i++) begin
      bit v;
      v = (i % 3 != 1);
      in_valid = v;
      in_re = DW'(100 * i - 300);
      in_im = DW'(-7 * i);
      @(negedge clk);
      check(out_valid == v, "R6 valid", int'(out_valid), int'(v));
      if (v) begin
        check(out_re == DW'(100 * i - 300), "R6 re", int'(out_re), 100 * i - 300);
        check(out_im == DW'(-7 * i), "R6 im", int'(out_im), -7 * i);
      end
    end
    in_valid = 1'b0;
    bypass = 1'b0;
    @(negedge clk);
    check(gate_en == 1'b1, "R7", int'(gate_en), 1);
  endtask

  task automatic t_restart();
    restart();
    for (int t = 0; t < 7; t++) drive(1'b1, 2500 - 300 * t, 1200);
    for (int t = 0; t < 64; t++) begin st_re[t] = 0; st_im[t] = 0; end
    st_re[0] = 4000;
    restart();
    stream(3 * N, 1'b1);
    check_impulse("R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_impulse();
    t_tone();
    t_bypass();
    t_restart();
    check(r5_viol == 0, "R5", r5_viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule